// File: doc/BRIEF.md
# Sync Word Padding Injector

After the main configuration image has been streamed into a target device, the device may still need extra clock edges before it reports early user mode. This block supplies them. On a start pulse it captures the current clock-to-data ratio setting, rewrites the ratio to its x1 code, and then sends all-ones 32-bit padding words one at a time over a valid/ready data port. After each accepted word it waits a fixed gap, then looks at the early-user-mode status input again. Padding stops as soon as that status is seen high. The block then writes the captured ratio back and raises `done`.

A single timeout covers the whole wait. It is measured from the first busy cycle. If it expires before the status rises, the block raises `err_timeout` and leaves the ratio at x1. In both cases the number of accepted padding words stays visible on `word_cnt` until the next start. Timing comes from the clock frequency parameter. One microsecond prescaler feeds the per-word gap, and a second prescaler feeds the millisecond timeout.

The controller has eight states. IDLE waits for a start. SAVE issues the x1 ratio write. CHECK samples the status. SEND presents a word. GAP waits between words. RESTORE writes back the captured ratio. DONE and FAIL hold the result. The transitions are:
- start: IDLE/DONE/FAIL→SAVE
- SAVE→CHECK
- status high: CHECK→RESTORE
- timeout: CHECK→FAIL
- otherwise: CHECK→SEND
- ready: SEND→GAP
- timeout without ready: SEND→FAIL
- timeout: GAP→FAIL
- gap elapsed: GAP→CHECK
- RESTORE→DONE

Top module: `pad_injector`

## Requirements
- R1: After reset the block is idle. `pad_valid`, `ratio_wr_en`, `done` and `err_timeout` are low, and `word_cnt` is 0.
- R2: A start accepted while not busy captures `ratio_cur`. In the next cycle `ratio_wr_en` pulses for exactly one cycle with `ratio_wr_data` equal to the x1 code (parameter `RATIO_X1`, default 0).
- R3: Every padding word is presented with `pad_data` all ones. A word counts only in a cycle where `pad_valid` and `pad_ready` are both high.
- R4: The status input is sampled in the CHECK state. If it is high there, no further word is sent. In particular, with the status already high at start, `word_cnt` finishes at 0.
- R5: After each accepted word, exactly GAP_US × (CLK_HZ/1e6) cycles pass in the gap before the status is sampled again. A status rise during the gap does not shorten it.
- R6: On success, `ratio_wr_en` pulses for one cycle with the captured ratio. `done` then rises in the following cycle and holds.
- R7: If TIMEOUT_MS × 1000 × (CLK_HZ/1e6) busy cycles pass before success, `err_timeout` rises and holds. No restore write is made, and `pad_valid` is low from then on.
- R8: `word_cnt` equals the number of accepted words. It is cleared by an accepted start and holds after the block finishes.
- R9: A start while busy is ignored: the captured ratio and the progress are unchanged. A start in DONE or FAIL clears the flag and begins a new run.
- R10: Once raised, `pad_valid` stays high with unchanged data until the word is accepted or the timeout fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse |
| early_um | input | 1 | Early-user-mode status from the target |
| ratio_cur | input | RATIO_W | Current clock-to-data ratio setting |
| ratio_wr_en | output | 1 | Ratio write strobe |
| ratio_wr_data | output | RATIO_W | Ratio value to write |
| pad_data | output | DATA_W | Padding word |
| pad_valid | output | 1 | Padding word valid |
| pad_ready | input | 1 | Sink accepts word |
| done | output | 1 | Success flag, held until next start |
| err_timeout | output | 1 | Timeout flag, held until next start |
| word_cnt | output | CNT_W | Accepted padding words |

## Verification
A wrong state or transition shows at the ports within one cycle. A stray or missing `ratio_wr_en` pulse, a `pad_valid` at the wrong time, or an early `done` all appear immediately. An off-by-one in the gap or the timeout counter shifts the next `pad_valid` rise, or the `err_timeout` rise, by a cycle. An error in the captured ratio only surfaces at the restore write, which can be hundreds of cycles later. A counting error surfaces on `word_cnt` in the cycle after the handshake. A behavioural reference model is therefore compared against every output on every cycle. This catches each of these faults in the cycle it first appears.

// File: rtl/pad_pkg.sv
package pad_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_SAVE,
        S_CHECK,
        S_SEND,
        S_GAP,
        S_RESTORE,
        S_DONE,
        S_FAIL
    } pad_state_e;

    localparam int US_PER_MS = 1000;
    localparam int HZ_PER_MHZ = 1_000_000;
endpackage

// File: rtl/tick_div.sv
module tick_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [W-1:0] cnt_q;
    logic         at_last;

    assign at_last = (cnt_q == W'(DIV - 1));
    assign tick    = en && !clr && at_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= at_last ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pad_interval.sv
module pad_interval #(
    parameter int CYC_PER_US = 1,
    parameter int COUNT_US   = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expire
);
    logic us_tick;

    tick_div #(.DIV(CYC_PER_US)) u_us (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .en   (run),
        .tick (us_tick)
    );

    tick_div #(.DIV(COUNT_US)) u_span (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .en   (us_tick),
        .tick (expire)
    );
endmodule

// File: rtl/pad_injector.sv
module pad_injector
    import pad_pkg::*;
#(
    parameter int CLK_HZ     = 125_000_000,
    parameter int GAP_US     = 1000,
    parameter int TIMEOUT_MS = 1000,
    parameter int RATIO_W    = 2,
    parameter int RATIO_X1   = 0,
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               early_um,
    input  logic [RATIO_W-1:0] ratio_cur,
    output logic               ratio_wr_en,
    output logic [RATIO_W-1:0] ratio_wr_data,
    output logic [DATA_W-1:0]  pad_data,
    output logic               pad_valid,
    input  logic               pad_ready,
    output logic               done,
    output logic               err_timeout,
    output logic [CNT_W-1:0]   word_cnt
);
    localparam int CYC_PER_US = (CLK_HZ / HZ_PER_MHZ > 0) ? CLK_HZ / HZ_PER_MHZ : 1;
    localparam int TO_US      = TIMEOUT_MS * US_PER_MS;
    localparam logic [RATIO_W-1:0] X1_CODE = RATIO_W'(RATIO_X1);

    pad_state_e         st_q, st_nx;
    logic [RATIO_W-1:0] saved_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               to_flag_q;
    logic               busy, arm, accepted;
    logic               gap_exp, to_exp, time_up;

    assign busy     = (st_q == S_SAVE) || (st_q == S_CHECK) || (st_q == S_SEND) ||
                      (st_q == S_GAP)  || (st_q == S_RESTORE);
    assign arm      = start && !busy;
    assign accepted = (st_q == S_SEND) && pad_ready;
    assign time_up  = to_flag_q || to_exp;

    pad_interval #(.CYC_PER_US(CYC_PER_US), .COUNT_US(GAP_US)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (st_q != S_GAP),
        .run   (1'b1),
        .expire(gap_exp)
    );

    pad_interval #(.CYC_PER_US(CYC_PER_US), .COUNT_US(TO_US)) u_timeout (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!busy),
        .run   (busy),
        .expire(to_exp)
    );

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            S_IDLE, S_DONE, S_FAIL: if (start) st_nx = S_SAVE;
            S_SAVE:    st_nx = S_CHECK;
            S_CHECK: begin
                if (early_um)     st_nx = S_RESTORE;
                else if (time_up) st_nx = S_FAIL;
                else              st_nx = S_SEND;
            end
            S_SEND: begin
                if (pad_ready)    st_nx = S_GAP;
                else if (time_up) st_nx = S_FAIL;
            end
            S_GAP: begin
                if (time_up)      st_nx = S_FAIL;
                else if (gap_exp) st_nx = S_CHECK;
            end
            S_RESTORE: st_nx = S_DONE;
            default:   st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= S_IDLE;
            saved_q   <= '0;
            cnt_q     <= '0;
            to_flag_q <= 1'b0;
        end else begin
            st_q      <= st_nx;
            to_flag_q <= busy ? time_up : 1'b0;
            if (arm) begin
                saved_q <= ratio_cur;
                cnt_q   <= '0;
            end else if (accepted) begin
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        pad_data      = '1;
        pad_valid     = (st_q == S_SEND);
        ratio_wr_en   = (st_q == S_SAVE) || (st_q == S_RESTORE);
        ratio_wr_data = (st_q == S_RESTORE) ? saved_q : X1_CODE;
        done          = (st_q == S_DONE);
        err_timeout   = (st_q == S_FAIL);
        word_cnt      = cnt_q;
    end

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_wr_en |=> !ratio_wr_en); // R2
    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_valid && !pad_ready && !time_up) |=> (pad_valid && $stable(pad_data))); // R10
    AST_DONE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(ratio_wr_en)); // R6
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err_timeout)); // R7
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ((word_cnt == $past(word_cnt)) || (word_cnt == $past(word_cnt) + 1'b1))); // R8
    AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err_timeout) |-> !pad_valid); // R7
endmodule

// File: tb/pad_injector_tb.sv
module pad_injector_tb;
    localparam int CLK_HZ = 2_000_000;
    localparam int GAP_US = 3;
    localparam int TO_MS  = 1;
    localparam int CPU    = CLK_HZ / 1_000_000;
    localparam int GAP_CYC = GAP_US * CPU;
    localparam int TO_CYC  = TO_MS * 1000 * CPU;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        start = 0;
    logic        early_um = 0;
    logic [1:0]  ratio_cur = 2'd0;
    logic        ratio_wr_en;
    logic [1:0]  ratio_wr_data;
    logic [31:0] pad_data;
    logic        pad_valid;
    logic        pad_ready = 1;
    logic        done, err_timeout;
    logic [15:0] word_cnt;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int rdy_mode = 0;

    always #4 clk = ~clk;

    pad_injector #(.CLK_HZ(CLK_HZ), .GAP_US(GAP_US), .TIMEOUT_MS(TO_MS)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .early_um(early_um),
        .ratio_cur(ratio_cur), .ratio_wr_en(ratio_wr_en), .ratio_wr_data(ratio_wr_data),
        .pad_data(pad_data), .pad_valid(pad_valid), .pad_ready(pad_ready),
        .done(done), .err_timeout(err_timeout), .word_cnt(word_cnt)
    );

    // behavioural reference: 0 idle 1 save 2 check 3 send 4 gap 5 restore 6 done 7 fail
    int       m_ph = 0, m_bc = 0, m_gc = 0, m_cnt = 0;
    bit       m_tup = 0;
    logic [1:0] m_saved = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_bc = 0; m_gc = 0; m_cnt = 0; m_tup = 0; m_saved = 0;
        end else begin
            int prev, idx, gidx;
            bit busy, tup;
            prev = m_ph;
            busy = (m_ph >= 1) && (m_ph <= 5);
            idx  = m_bc + 1;
            gidx = m_gc + 1;
            tup  = m_tup || (busy && idx == TO_CYC);
            case (m_ph)
                0, 6, 7: if (start) begin m_ph = 1; m_saved = ratio_cur; m_cnt = 0; end
                1: m_ph = 2;
                2: if (early_um) m_ph = 5; else if (tup) m_ph = 7; else m_ph = 3;
                3: if (pad_ready) begin m_cnt = (m_cnt + 1) % 65536; m_ph = 4; end
                   else if (tup) m_ph = 7;
                4: if (tup) m_ph = 7; else if (gidx == GAP_CYC) m_ph = 2;
                5: m_ph = 6;
                default: m_ph = 0;
            endcase
            m_gc  = (prev == 4 && m_ph == 4) ? gidx : 0;
            m_bc  = busy ? idx : 0;
            m_tup = busy ? tup : 1'b0;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 R5 R10 pad_valid", pad_valid, m_ph == 3);
            if (m_ph == 3) chk("R3 pad_data", pad_data, 32'hFFFF_FFFF);
            chk("R2 R6 ratio_wr_en", ratio_wr_en, (m_ph == 1) || (m_ph == 5));
            if (m_ph == 1) chk("R2 x1 write", ratio_wr_data, 2'd0);
            if (m_ph == 5) chk("R6 R9 restore write", ratio_wr_data, m_saved);
            chk("R4 R6 done", done, m_ph == 6);
            chk("R7 err_timeout", err_timeout, m_ph == 7);
            chk("R8 word_cnt", word_cnt, m_cnt);
        end
        if (rdy_mode == 1) pad_ready <= ~pad_ready;
        else if (rdy_mode == 2) pad_ready <= (cyc % 5 == 0);
        else pad_ready <= 1'b1;
    end

    task automatic summary_and_end();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            failures++;
            $display("FAIL R9 watchdog actual=%0d expected=<150000", cyc);
            summary_and_end();
        end
    end

    task automatic pulse_start(input logic [1:0] r);
        @(negedge clk);
        ratio_cur = r;
        start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (done || err_timeout) break;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset valid", pad_valid, 0);
        chk("R1 reset done", done, 0);
        chk("R1 reset err", err_timeout, 0);
        chk("R1 reset cnt", word_cnt, 0);
        chk("R1 reset wr", ratio_wr_en, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R4: status already high
        early_um = 1;
        pulse_start(2'd3);
        wait_end();
        chk("R4 no words", word_cnt, 0);
        chk("R6 done held", done, 1);

        // R5: status rises after some words, ready always high
        early_um = 0;
        pulse_start(2'd2);
        repeat (45) @(negedge clk);
        early_um = 1;
        wait_end();
        chk("R8 count nonzero", word_cnt > 0, 1);
        chk("R6 done", done, 1);

        // R10 R9: stalled ready, start ignored mid-run
        early_um = 0;
        rdy_mode = 2;
        pulse_start(2'd1);
        repeat (20) @(negedge clk);
        pulse_start(2'd3);
        repeat (60) @(negedge clk);
        early_um = 1;
        wait_end();
        chk("R9 done after ignored start", done, 1);

        // R7: timeout with alternating ready
        early_um = 0;
        rdy_mode = 1;
        pulse_start(2'd2);
        wait_end();
        chk("R7 timeout flag", err_timeout, 1);
        chk("R7 no done", done, 0);

        // R9: restart from FAIL clears the flag
        rdy_mode = 0;
        early_um = 1;
        pulse_start(2'd1);
        chk("R9 err cleared", err_timeout, 0);
        wait_end();
        chk("R9 done after restart", done, 1);
        chk("R4 count zero", word_cnt, 0);

        summary_and_end();
    end
endmodule